// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

The block holds up to eight pending memory requests, each tagged with a bank, a row and a read or write flag. Every cycle it picks one of them for issue to the DRAM banks. It also reports which command that request needs first.

The open-row state of every bank arrives as an input. With that state the scheduler can see which pending requests would hit the row already latched in their bank.

In the default policy, requests that hit are served before any request that needs a row command. Age decides the order inside each of the two groups. A mode input switches to strict first-come order: only the single oldest request may be granted.

A request counts only while the ready input of its bank is high. A granted request leaves the queue at the next clock edge. Per-bank timing and data return are handled outside the block.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset the queue is empty, `gnt_valid_o` is 0 and `gnt_onehot_o` is all zero.
- R2: A request presented with `req_valid_i` high at a clock edge is stored in a free entry. It can be granted from the cycle after that edge. A request presented while all 8 entries are occupied is dropped and is never granted.
- R3: An entry can be granted only while `bank_ready_i[bank]` is high for its bank. When no entry qualifies, `gnt_valid_o` is 0.
- R4: With `fcfs_mode_i` low, a request whose bank is open (`bank_open_i[bank]` = 1) on the same row is chosen ahead of every request that needs a row command.
- R5: Within the row-hit group, and within the row-command group, the request that arrived earliest is chosen.
- R6: `gnt_cmd_o` gives the first command needed by the granted request. 2'b00 is a column read and 2'b01 a column write; both are used on a row hit. 2'b10 is activate, used when the bank is closed. 2'b11 is precharge, used when the bank has a different row open.
- R7: With `fcfs_mode_i` high, only the oldest stored request can be granted, and only while its bank is ready. Row state has no effect on which request is chosen.
- R8: While `gnt_valid_o` is 1, `gnt_onehot_o` has exactly one bit set, at `gnt_idx_o`. That entry is freed at the next clock edge and is never granted again.
- R9: The open row of bank b is read from bits [b*14 +: 14] of `bank_open_row_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fcfs_mode_i | input | 1 | 1 selects strict oldest-first order |
| req_valid_i | input | 1 | New request present |
| req_bank_i | input | 3 | Bank of the new request |
| req_row_i | input | 14 | Row of the new request |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| bank_ready_i | input | 8 | Per-bank ready to take a command |
| bank_open_i | input | 8 | Per-bank row-open flag |
| bank_open_row_i | input | 112 | Open row of each bank, 14 bits per bank |
| gnt_valid_o | output | 1 | A request is granted this cycle |
| gnt_onehot_o | output | 8 | One-hot granted entry |
| gnt_idx_o | output | 3 | Index of the granted entry |
| gnt_cmd_o | output | 2 | First command for the granted request |
| gnt_bank_o | output | 3 | Bank of the granted request |
| gnt_row_o | output | 14 | Row of the granted request |

## Verification
A stored request can win one clock edge after it is presented.

The grant outputs are combinational from the stored queue and the current ready and open-row inputs, so each grant is due in the same cycle those inputs are set. The granted entry is gone after the following edge.

The bench drives inputs at the falling edge and loads the scoreboard with the expected grant for every cycle of a phase, idle cycles included. The monitor compares shortly after that falling edge, before the rising edge that removes the entry.

// File: rtl/frfcfs_pkg.sv
package frfcfs_pkg;
  typedef enum logic [1:0] {
    CMD_RD  = 2'b00,
    CMD_WR  = 2'b01,
    CMD_ACT = 2'b10,
    CMD_PRE = 2'b11
  } cmd_e;
endpackage

// File: rtl/sched_queue.sv
module sched_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              enq_i,
  input  logic [BANK_W-1:0]                 enq_bank_i,
  input  logic [ROW_W-1:0]                  enq_row_i,
  input  logic                              enq_write_i,
  input  logic [DEPTH-1:0]                  free_i,
  output logic [DEPTH-1:0]                  valid_o,
  output logic [DEPTH-1:0][BANK_W-1:0]      bank_o,
  output logic [DEPTH-1:0][ROW_W-1:0]       row_o,
  output logic [DEPTH-1:0]                  write_o,
  output logic [DEPTH-1:0][IDX_W-1:0]       rank_o
);
  logic [DEPTH-1:0]             valid_q;
  logic [DEPTH-1:0][BANK_W-1:0] bank_q;
  logic [DEPTH-1:0][ROW_W-1:0]  row_q;
  logic [DEPTH-1:0]             write_q;
  logic [DEPTH-1:0][IDX_W-1:0]  rank_q;

  logic [IDX_W-1:0] slot;
  logic             has_free;
  logic [IDX_W:0]   count;
  logic [IDX_W:0]   new_rank;
  logic             gnt_any;
  logic [IDX_W-1:0] gnt_rank;
  logic             has_oldest;

  always_comb begin
    slot       = '0;
    has_free   = 1'b0;
    count      = '0;
    gnt_rank   = '0;
    has_oldest = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        slot     = IDX_W'(i);
        has_free = 1'b1;
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      count = count + (IDX_W + 1)'(valid_q[i]);
      if (free_i[i]) gnt_rank = gnt_rank | rank_q[i];
      if (valid_q[i] && rank_q[i] == '0) has_oldest = 1'b1;
    end
  end

  assign gnt_any  = |free_i;
  // a grant in the same cycle shifts everyone younger down by one
  assign new_rank = count - (IDX_W + 1)'(gnt_any);

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        bank_q[i]  <= '0;
        row_q[i]   <= '0;
        write_q[i] <= 1'b0;
        rank_q[i]  <= '0;
      end else if (free_i[i]) begin
        valid_q[i] <= 1'b0;
      end else if (valid_q[i]) begin
        if (gnt_any && rank_q[i] > gnt_rank) rank_q[i] <= rank_q[i] - 1'b1;
      end else if (enq_i && has_free && slot == IDX_W'(i)) begin
        valid_q[i] <= 1'b1;
        bank_q[i]  <= enq_bank_i;
        row_q[i]   <= enq_row_i;
        write_q[i] <= enq_write_i;
        rank_q[i]  <= new_rank[IDX_W-1:0];
      end
    end
  end

  assign valid_o = valid_q;
  assign bank_o  = bank_q;
  assign row_o   = row_q;
  assign write_o = write_q;
  assign rank_o  = rank_q;

  // R5
  oldest_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q != '0) |-> has_oldest);

  // R8
  freed_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i != '0) |=> ((valid_q & $past(free_i)) == '0));
endmodule

// File: rtl/sched_pick.sv
module sched_pick #(
  parameter int DEPTH  = 8,
  parameter int RANK_W = 3
) (
  input  logic [DEPTH-1:0]             mask_i,
  input  logic [DEPTH-1:0][RANK_W-1:0] rank_i,
  output logic [DEPTH-1:0]             pick_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    always_comb begin
      pick_o[i] = mask_i[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (mask_i[j] && rank_i[j] < rank_i[i]) pick_o[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched
  import frfcfs_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  localparam int NBANK = 1 << BANK_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fcfs_mode_i,
  input  logic                   req_valid_i,
  input  logic [BANK_W-1:0]      req_bank_i,
  input  logic [ROW_W-1:0]       req_row_i,
  input  logic                   req_write_i,
  input  logic [NBANK-1:0]       bank_ready_i,
  input  logic [NBANK-1:0]       bank_open_i,
  input  logic [NBANK*ROW_W-1:0] bank_open_row_i,
  output logic                   gnt_valid_o,
  output logic [DEPTH-1:0]       gnt_onehot_o,
  output logic [IDX_W-1:0]       gnt_idx_o,
  output logic [1:0]             gnt_cmd_o,
  output logic [BANK_W-1:0]      gnt_bank_o,
  output logic [ROW_W-1:0]       gnt_row_o
);
  logic [DEPTH-1:0]             q_valid;
  logic [DEPTH-1:0][BANK_W-1:0] q_bank;
  logic [DEPTH-1:0][ROW_W-1:0]  q_row;
  logic [DEPTH-1:0]             q_write;
  logic [DEPTH-1:0][IDX_W-1:0]  q_rank;

  logic [DEPTH-1:0] eligible, hit, pick_hit, pick_elig, pick_old, sel;
  logic             gnt_write;
  logic             gnt_hit;

  sched_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_queue (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enq_i      (req_valid_i),
    .enq_bank_i (req_bank_i),
    .enq_row_i  (req_row_i),
    .enq_write_i(req_write_i),
    .free_i     (sel),
    .valid_o    (q_valid),
    .bank_o     (q_bank),
    .row_o      (q_row),
    .write_o    (q_write),
    .rank_o     (q_rank)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_class
    assign eligible[i] = q_valid[i] && bank_ready_i[q_bank[i]];
    assign hit[i]      = eligible[i] && bank_open_i[q_bank[i]] &&
                         bank_open_row_i[q_bank[i]*ROW_W +: ROW_W] == q_row[i];
  end

  sched_pick #(.DEPTH(DEPTH), .RANK_W(IDX_W)) u_pick_hit (
    .mask_i(hit), .rank_i(q_rank), .pick_o(pick_hit));
  sched_pick #(.DEPTH(DEPTH), .RANK_W(IDX_W)) u_pick_elig (
    .mask_i(eligible), .rank_i(q_rank), .pick_o(pick_elig));
  sched_pick #(.DEPTH(DEPTH), .RANK_W(IDX_W)) u_pick_old (
    .mask_i(q_valid), .rank_i(q_rank), .pick_o(pick_old));

  always_comb begin
    if (fcfs_mode_i)   sel = pick_old & eligible;
    else if (|hit)     sel = pick_hit;
    else               sel = pick_elig;
  end

  always_comb begin
    gnt_idx_o  = '0;
    gnt_bank_o = '0;
    gnt_row_o  = '0;
    gnt_write  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel[i]) begin
        gnt_idx_o  = gnt_idx_o | IDX_W'(i);
        gnt_bank_o = gnt_bank_o | q_bank[i];
        gnt_row_o  = gnt_row_o | q_row[i];
        gnt_write  = gnt_write | q_write[i];
      end
    end
  end

  assign gnt_hit = bank_open_i[gnt_bank_o] &&
                   bank_open_row_i[gnt_bank_o*ROW_W +: ROW_W] == gnt_row_o;

  always_comb begin
    if (gnt_hit)                      gnt_cmd_o = gnt_write ? CMD_WR : CMD_RD;
    else if (bank_open_i[gnt_bank_o]) gnt_cmd_o = CMD_PRE;
    else                              gnt_cmd_o = CMD_ACT;
  end

  assign gnt_valid_o  = |sel;
  assign gnt_onehot_o = sel;

  // R8
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> ($onehot(gnt_onehot_o) && gnt_onehot_o[gnt_idx_o]));

  // R3
  gnt_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> bank_ready_i[gnt_bank_o]);

  // R3
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eligible == '0) |-> !gnt_valid_o);

  // R4
  hit_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fcfs_mode_i && hit != '0) |-> (gnt_valid_o && !gnt_cmd_o[1]));

  // R7
  fcfs_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcfs_mode_i && gnt_valid_o) |-> (q_rank[gnt_idx_o] == '0));
endmodule

// File: tb/frfcfs_sched_test.sv
module frfcfs_sched_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fcfs = 1'b0;
  logic         req_v = 1'b0;
  logic [2:0]   req_bank = '0;
  logic [13:0]  req_row = '0;
  logic         req_wr = 1'b0;
  logic [7:0]   ready = '0;
  logic [7:0]   bopen = '0;
  logic [111:0] orow = '0;
  logic         gv;
  logic [7:0]   goh;
  logic [2:0]   gidx;
  logic [1:0]   gcmd;
  logic [2:0]   gbank;
  logic [13:0]  grow;

  int checks = 0;
  int fails  = 0;
  logic  mon_en = 1'b0;
  logic [19:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  frfcfs_sched uut (
    .clk_i(clk), .rst_ni(rst_n), .fcfs_mode_i(fcfs),
    .req_valid_i(req_v), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_write_i(req_wr), .bank_ready_i(ready), .bank_open_i(bopen),
    .bank_open_row_i(orow), .gnt_valid_o(gv), .gnt_onehot_o(goh),
    .gnt_idx_o(gidx), .gnt_cmd_o(gcmd), .gnt_bank_o(gbank), .gnt_row_o(grow));

  task automatic expect_gnt(input logic v, input logic [2:0] b,
                            input logic [13:0] r, input logic [1:0] c,
                            input string tag);
    exp_q.push_back({v, b, r, c});
    tag_q.push_back(tag);
  endtask

  task automatic enq(input logic [2:0] b, input logic [13:0] r, input logic w);
    @(negedge clk);
    req_v = 1'b1; req_bank = b; req_row = r; req_wr = w;
    @(negedge clk);
    req_v = 1'b0;
  endtask

  task automatic set_open(input int b, input logic [13:0] r);
    bopen[b] = 1'b1;
    orow[b*14 +: 14] = r;
  endtask

  // run the expected items queued so far under the given inputs
  task automatic run_phase(input logic [7:0] rdy, input logic mode);
    @(negedge clk);
    ready = rdy; fcfs = mode; mon_en = 1'b1;
    while (exp_q.size() != 0) @(posedge clk);
    @(negedge clk);
    mon_en = 1'b0; ready = '0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (mon_en && exp_q.size() != 0) begin
        logic [19:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (gv !== e[19] ||
            (e[19] && (gbank !== e[18:16] || grow !== e[15:2] || gcmd !== e[1:0] ||
                       !$onehot(goh) || goh[gidx] !== 1'b1))) begin
          fails++;
          $display("FAIL %s: got v=%0b bank=%0d row=%0d cmd=%0d oh=%b, expected v=%0b bank=%0d row=%0d cmd=%0d",
                   t, gv, gbank, grow, gcmd, goh, e[19], e[18:16], e[15:2], e[1:0]);
        end
      end
    end
  end

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (gv !== 1'b0 || goh !== 8'h00) begin
      fails++;
      $display("FAIL R1: got v=%0b oh=%b, expected v=0 oh=00000000", gv, goh);
    end
    @(negedge clk); rst_n = 1'b1;

    // R4 R5 R6 R9: hits first, oldest first in each group
    enq(3'd1, 14'd5, 1'b0);
    enq(3'd2, 14'd7, 1'b1);
    enq(3'd1, 14'd9, 1'b1);
    enq(3'd2, 14'd3, 1'b0);
    set_open(1, 14'd9);
    set_open(2, 14'd3);
    expect_gnt(1, 3'd1, 14'd9, 2'b01, "R4 oldest hit write");
    expect_gnt(1, 3'd2, 14'd3, 2'b00, "R5 second hit read");
    expect_gnt(1, 3'd1, 14'd5, 2'b11, "R6 precharge oldest miss");
    expect_gnt(1, 3'd2, 14'd7, 2'b11, "R9 precharge bank2");
    expect_gnt(0, 3'd0, 14'd0, 2'b00, "R8 freed entries not regranted");
    run_phase(8'hFF, 1'b0);
    bopen = '0; orow = '0;

    // R6: closed banks need activate, arrival order kept
    enq(3'd4, 14'd1, 1'b0);
    enq(3'd3, 14'd2, 1'b1);
    enq(3'd4, 14'd1, 1'b1);
    expect_gnt(1, 3'd4, 14'd1, 2'b10, "R6 activate first");
    expect_gnt(1, 3'd3, 14'd2, 2'b10, "R5 activate second");
    expect_gnt(1, 3'd4, 14'd1, 2'b10, "R5 activate third");
    expect_gnt(0, 3'd0, 14'd0, 2'b00, "R8 empty after drain");
    run_phase(8'hFF, 1'b0);

    // R3: bank readiness gates eligibility
    enq(3'd5, 14'd10, 1'b0);
    enq(3'd6, 14'd11, 1'b0);
    set_open(5, 14'd10);
    set_open(6, 14'd11);
    expect_gnt(1, 3'd6, 14'd11, 2'b00, "R3 only ready bank granted");
    expect_gnt(0, 3'd0, 14'd0, 2'b00, "R3 unready bank held");
    expect_gnt(0, 3'd0, 14'd0, 2'b00, "R3 unready bank still held");
    run_phase(8'h40, 1'b0);
    expect_gnt(1, 3'd5, 14'd10, 2'b00, "R3 granted once ready");
    expect_gnt(0, 3'd0, 14'd0, 2'b00, "R3 drained");
    run_phase(8'h20, 1'b0);
    bopen = '0; orow = '0;

    // R7: strict oldest-first ignores row hits and waits on oldest
    enq(3'd0, 14'd20, 1'b0);
    enq(3'd7, 14'd30, 1'b0);
    set_open(0, 14'd99);
    set_open(7, 14'd30);
    expect_gnt(0, 3'd0, 14'd0, 2'b00, "R7 oldest not ready blocks");
    expect_gnt(0, 3'd0, 14'd0, 2'b00, "R7 younger hit not taken");
    run_phase(8'h80, 1'b1);
    expect_gnt(1, 3'd0, 14'd20, 2'b11, "R7 oldest first despite hit");
    expect_gnt(1, 3'd7, 14'd30, 2'b00, "R7 then younger");
    expect_gnt(0, 3'd0, 14'd0, 2'b00, "R7 drained");
    run_phase(8'hFF, 1'b1);
    bopen = '0; orow = '0;

    // R2: nine arrivals into eight entries, ninth dropped
    for (int i = 0; i < 8; i++) enq(3'(i), 14'(100 + i), 1'b0);
    enq(3'd0, 14'd200, 1'b0);
    for (int i = 0; i < 8; i++) expect_gnt(1, 3'(i), 14'(100 + i), 2'b10, "R2 stored entry");
    expect_gnt(0, 3'd0, 14'd0, 2'b00, "R2 overflow request dropped");
    expect_gnt(0, 3'd0, 14'd0, 2'b00, "R2 still nothing left");
    run_phase(8'hFF, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule